// File: doc/BRIEF.md
# Shared-Pin GPIO Controller with Ownership Arbitration

This block drives a small group of general-purpose pins that also act as SPI chip selects. Each pin comes out as three separate signals: an output value, an output enable, and an input. The host can ask for the GPIO port to be turned on or off. While the port is on, the host writes a direction mask and a value mask that set which pins drive and what level they drive. The controller decides who owns the pins at any moment: the GPIO port, the SPI engine (which uses the pins as chip selects), or nobody.

The GPIO port can be on only while both the JTAG engine and the SPI engine are idle. If either engine is active when an enable request arrives, the request is refused and a status flag is set. If either engine becomes active while the port is on, the port is shut off by force. Every time the port turns off, the direction and value masks are cleared, so the next enable always starts with all pins released. Pin inputs pass through a synchronizer and can be read at any time, whoever owns the pins.

Top module: `gpio_share_ctrl`

## Requirements
- R1: After reset, and after any later reset, `pin_oe`, `pin_o`, `port_en`, `en_refused` and `rd_data` are all zero.
- R2: An enable request with JTAG and SPI both idle and no disable request sets `port_en` at the next clock edge and clears `en_refused`.
- R3: An enable request while JTAG or SPI is active leaves `port_en` low and sets `en_refused` at the next edge. The flag stays set until an enable request is accepted.
- R4: While the port is on, a direction write sets `pin_oe` to the written mask and a value write sets `pin_o` to the written mask, both from the next edge. Bit i of each mask controls pin i.
- R5: Direction and value writes made while the port is off have no effect: after a later enable, every pin is still released.
- R6: A disable request turns the port off at the next edge and releases all pins. The masks are cleared, so a later enable starts with every pin released.
- R7: When JTAG or SPI becomes active while the port is on, the pins leave GPIO control in the same cycle, and the port turns off with its masks cleared at the next edge.
- R8: While SPI is active and the GPIO port does not own the pins, `pin_oe` follows `spi_cs_oe` and `pin_o` follows `spi_cs_val`.
- R9: While JTAG is active and SPI is idle, every pin is released (`pin_oe` and `pin_o` are zero).
- R10: `rd_data` shows `pin_i` as it was two clock edges earlier, whoever owns the pins.
- R11: When enable and disable requests arrive in the same cycle, the disable wins: `port_en` ends up low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| jtag_active | input | 1 | The JTAG engine holds the shared pins |
| spi_active | input | 1 | The SPI engine holds the shared pins |
| gpio_en_req | input | 1 | One-cycle request to turn the GPIO port on |
| gpio_dis_req | input | 1 | One-cycle request to turn the GPIO port off |
| gpio_wr_dir | input | 1 | Write strobe for the direction mask |
| gpio_wr_val | input | 1 | Write strobe for the value mask |
| gpio_wr_data | input | NUM_PINS | Data for the direction or value write |
| spi_cs_oe | input | NUM_PINS | Chip-select output enables from the SPI engine |
| spi_cs_val | input | NUM_PINS | Chip-select levels from the SPI engine |
| pin_i | input | NUM_PINS | Pin input levels |
| pin_o | output | NUM_PINS | Pin output levels |
| pin_oe | output | NUM_PINS | Pin output enables (1 = drive) |
| port_en | output | 1 | The GPIO port is on |
| en_refused | output | 1 | The last enable request was refused |
| rd_data | output | NUM_PINS | Synchronized pin inputs |

## Verification
Port state, the refusal flag and the masks are registered, so their effects are due one edge after the request or write. Pin ownership is decided combinationally from the engine-active inputs, so a change in JTAG or SPI activity shows on the pins within the same cycle. Synchronized inputs are due two edges after `pin_i` changes. The bench drives every stimulus on the falling edge, lets exactly one rising edge pass, and samples 2 ns later while the inputs are still held. For the synchronizer, it samples after the first edge to see the old value and after the second edge to see the new one.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

    // who currently holds the shared pins
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_JTAG = 2'd1,
        OWN_SPI  = 2'd2,
        OWN_GPIO = 2'd3
    } owner_e;

    localparam int unsigned DEF_PINS = 3;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NUM_PINS = 3,
    parameter int unsigned STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][NUM_PINS-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
    parameter int unsigned NUM_PINS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                jtag_active,
    input  logic                spi_active,
    input  logic                en_req,
    input  logic                dis_req,
    input  logic                wr_dir,
    input  logic                wr_val,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic                port_en,
    output logic                refused,
    output logic [NUM_PINS-1:0] dir_mask,
    output logic [NUM_PINS-1:0] val_mask
);
    typedef struct packed {
        logic                en;
        logic                refused;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] val;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     engine_busy;
    logic     accept;

    always_comb begin
        engine_busy = jtag_active | spi_active;
        accept      = en_req & ~engine_busy & ~dis_req;
        st_d        = st_q;

        if (accept) begin
            st_d.en      = 1'b1;
            st_d.refused = 1'b0;
        end else if (en_req && engine_busy) begin
            st_d.refused = 1'b1;
        end

        if (dis_req || engine_busy) st_d.en = 1'b0;

        // writes only land while the port is on and stays on
        if (st_q.en && st_d.en) begin
            if (wr_dir) st_d.dir = wr_data;
            if (wr_val) st_d.val = wr_data;
        end

        if (!st_d.en) begin
            st_d.dir = '0;
            st_d.val = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign port_en  = st_q.en;
    assign refused  = st_q.refused;
    assign dir_mask = st_q.dir;
    assign val_mask = st_q.val;

    // R3
    refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req && (jtag_active || spi_active)) |=> (refused && !port_en));

    // R7
    busy_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_active || spi_active) |=> !port_en);

    // R11
    disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> (!port_en && dir_mask == '0 && val_mask == '0));

    // R2
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req && !dis_req && !jtag_active && !spi_active) |=> (port_en && !refused));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_share_pkg::*;
#(
    parameter int unsigned NUM_PINS = 3
) (
    input  logic                port_en,
    input  logic                jtag_active,
    input  logic                spi_active,
    input  logic [NUM_PINS-1:0] dir_mask,
    input  logic [NUM_PINS-1:0] val_mask,
    input  logic [NUM_PINS-1:0] cs_oe,
    input  logic [NUM_PINS-1:0] cs_val,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_o
);
    owner_e owner;

    always_comb begin
        if (port_en && !jtag_active && !spi_active) owner = OWN_GPIO;
        else if (spi_active)                        owner = OWN_SPI;
        else if (jtag_active)                       owner = OWN_JTAG;
        else                                        owner = OWN_NONE;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            unique case (owner)
                OWN_GPIO: begin
                    pin_oe[p] = dir_mask[p];
                    pin_o[p]  = val_mask[p];
                end
                OWN_SPI: begin
                    pin_oe[p] = cs_oe[p];
                    pin_o[p]  = cs_val[p];
                end
                default: begin
                    pin_oe[p] = 1'b0;
                    pin_o[p]  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_share_ctrl.sv
module gpio_share_ctrl
    import gpio_share_pkg::*;
#(
    parameter int unsigned NUM_PINS    = DEF_PINS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                jtag_active,
    input  logic                spi_active,
    input  logic                gpio_en_req,
    input  logic                gpio_dis_req,
    input  logic                gpio_wr_dir,
    input  logic                gpio_wr_val,
    input  logic [NUM_PINS-1:0] gpio_wr_data,
    input  logic [NUM_PINS-1:0] spi_cs_oe,
    input  logic [NUM_PINS-1:0] spi_cs_val,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pin_o,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                port_en,
    output logic                en_refused,
    output logic [NUM_PINS-1:0] rd_data
);
    logic [NUM_PINS-1:0] dir_mask;
    logic [NUM_PINS-1:0] val_mask;

    gpio_port_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .jtag_active(jtag_active),
        .spi_active (spi_active),
        .en_req     (gpio_en_req),
        .dis_req    (gpio_dis_req),
        .wr_dir     (gpio_wr_dir),
        .wr_val     (gpio_wr_val),
        .wr_data    (gpio_wr_data),
        .port_en    (port_en),
        .refused    (en_refused),
        .dir_mask   (dir_mask),
        .val_mask   (val_mask)
    );

    gpio_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .port_en    (port_en),
        .jtag_active(jtag_active),
        .spi_active (spi_active),
        .dir_mask   (dir_mask),
        .val_mask   (val_mask),
        .cs_oe      (spi_cs_oe),
        .cs_val     (spi_cs_val),
        .pin_oe     (pin_oe),
        .pin_o      (pin_o)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i),
        .sync_o(rd_data)
    );

    // R9
    jtag_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jtag_active && !spi_active) |-> (pin_oe == '0));

    // R6
    off_port_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !spi_active) |-> (pin_oe == '0 && pin_o == '0));

    // R8
    spi_cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_active |-> (pin_oe == spi_cs_oe && pin_o == spi_cs_val));

endmodule

// File: tb/gpio_share_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_share_ctrl_bench;

    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          jtag_active = 1'b0, spi_active = 1'b0;
    logic          gpio_en_req = 1'b0, gpio_dis_req = 1'b0;
    logic          gpio_wr_dir = 1'b0, gpio_wr_val = 1'b0;
    logic [NP-1:0] gpio_wr_data = '0, spi_cs_oe = '0, spi_cs_val = '0, pin_i = '0;
    logic [NP-1:0] pin_o, pin_oe, rd_data;
    logic          port_en, en_refused;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    gpio_share_ctrl #(.NUM_PINS(NP)) u_gpio_share_ctrl (
        .clk(clk), .rst_n(rst_n),
        .jtag_active(jtag_active), .spi_active(spi_active),
        .gpio_en_req(gpio_en_req), .gpio_dis_req(gpio_dis_req),
        .gpio_wr_dir(gpio_wr_dir), .gpio_wr_val(gpio_wr_val),
        .gpio_wr_data(gpio_wr_data), .spi_cs_oe(spi_cs_oe),
        .spi_cs_val(spi_cs_val), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .port_en(port_en),
        .en_refused(en_refused), .rd_data(rd_data)
    );

    typedef struct packed {
        logic          jtag, spi, en, dis, wdir, wval;
        logic [NP-1:0] wdata, cs_oe, cs_val;
        logic          x_en, x_ref;
        logic [NP-1:0] x_oe, x_o;
    } vec_t;

    localparam int NV = 15;
    // fields: jtag spi en dis wdir wval wdata cs_oe cs_val | exp en ref oe o
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,0,0,3'b000,3'b000,3'b000, 0,0,3'b000,3'b000}, // R1 idle
        '{1,0,1,0,0,0,3'b000,3'b000,3'b000, 0,1,3'b000,3'b000}, // R3 R9 refused under jtag
        '{0,1,1,0,0,0,3'b000,3'b111,3'b101, 0,1,3'b111,3'b101}, // R3 R8 refused under spi
        '{0,0,0,0,1,1,3'b111,3'b000,3'b000, 0,1,3'b000,3'b000}, // R5 write while off
        '{0,0,1,0,0,0,3'b000,3'b000,3'b000, 1,0,3'b000,3'b000}, // R2 R5 accepted, masks clear
        '{0,0,0,0,1,0,3'b011,3'b000,3'b000, 1,0,3'b011,3'b000}, // R4 direction
        '{0,0,0,0,0,1,3'b110,3'b000,3'b000, 1,0,3'b011,3'b110}, // R4 value
        '{1,0,0,0,0,0,3'b000,3'b000,3'b000, 0,0,3'b000,3'b000}, // R7 jtag takes over
        '{0,0,1,0,0,0,3'b000,3'b000,3'b000, 1,0,3'b000,3'b000}, // R7 masks cleared
        '{0,0,0,0,1,1,3'b101,3'b000,3'b000, 1,0,3'b101,3'b101}, // R4 both writes
        '{0,0,1,1,0,0,3'b000,3'b000,3'b000, 0,0,3'b000,3'b000}, // R11 disable wins
        '{0,0,1,0,0,0,3'b000,3'b000,3'b000, 1,0,3'b000,3'b000}, // R6 re-enable clean
        '{0,0,0,0,1,1,3'b111,3'b000,3'b000, 1,0,3'b111,3'b111}, // R4 drive all
        '{0,0,0,1,0,0,3'b000,3'b000,3'b000, 0,0,3'b000,3'b000}, // R6 disable releases
        '{0,1,0,0,0,0,3'b000,3'b010,3'b000, 0,0,3'b010,3'b000}  // R8 spi chip select
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200_000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 reset pins", {10'd0, pin_oe, pin_o}, 16'd0);
        check("R1 reset status", {14'd0, port_en, en_refused}, 16'd0);
        check("R1 reset rd_data", {13'd0, rd_data}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            jtag_active  = VECS[i].jtag;
            spi_active   = VECS[i].spi;
            gpio_en_req  = VECS[i].en;
            gpio_dis_req = VECS[i].dis;
            gpio_wr_dir  = VECS[i].wdir;
            gpio_wr_val  = VECS[i].wval;
            gpio_wr_data = VECS[i].wdata;
            spi_cs_oe    = VECS[i].cs_oe;
            spi_cs_val   = VECS[i].cs_val;
            @(posedge clk);
            #2;
            check($sformatf("vector %0d", i),
                  {4'd0, port_en, en_refused, pin_oe, pin_o, 3'd0, 1'b0},
                  {4'd0, VECS[i].x_en, VECS[i].x_ref, VECS[i].x_oe, VECS[i].x_o, 3'd0, 1'b0});
        end

        // R10 two-edge synchronizer delay, independent of owner (spi still active)
        @(negedge clk);
        gpio_en_req = 1'b0; gpio_dis_req = 1'b0; gpio_wr_dir = 1'b0; gpio_wr_val = 1'b0;
        pin_i = 3'b101;
        @(posedge clk); #2;
        check("R10 after one edge", {13'd0, rd_data}, 16'd0);
        @(posedge clk); #2;
        check("R10 after two edges", {13'd0, rd_data}, 16'h5);

        // R1 reset while port on and driving
        @(negedge clk);
        spi_active = 1'b0; gpio_en_req = 1'b1;
        @(negedge clk);
        gpio_en_req = 1'b0; gpio_wr_dir = 1'b1; gpio_wr_val = 1'b1; gpio_wr_data = 3'b110;
        @(negedge clk);
        gpio_wr_dir = 1'b0; gpio_wr_val = 1'b0;
        check("R4 driving before reset", {10'd0, pin_oe, pin_o}, {10'd0, 3'b110, 3'b110});
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset pins", {10'd0, pin_oe, pin_o}, 16'd0);
        check("R1 mid-run reset status", {13'd0, port_en, en_refused, rd_data != 0}, 16'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule